// File: doc/BRIEF.md
# Stop-Clock Wake Controller

This block ends a stop-clock period when selected hardware activity shows up. It drives an active-low stop output that tells the clock logic to hold the processor clock. An external request pulse asserts that output. Any enabled wake source releases it. The same wake event also loads a hold counter with a programmed initial count. Every wake produces a one-cycle pulse that the surrounding power manager can observe.

Two 8-bit enable registers pick which sources may wake the processor. They are written and read over a small register bus with an address, a write strobe, write data and combinational read data. The sources are:

- seven interrupt request lines;
- the processor interrupt and NMI;
- SMI and external SMI;
- a suspend button and a battery-low signal;
- a serial ring-indicate line.

A master bit gates every source. The external-SMI, suspend-button and battery-low sources also need their SMI enable inputs, which come from outside the block. Each source is synchronized and edge-detected, so a level held active wakes the processor only once.

Top module: `clkstop_wake_ctrl`

## Requirements
- R1: After reset, both enable registers read 0x00, `stop_n_o` is 1, `hold_cnt_o` is 0 and `brk_pulse_o` is 0.
- R2: A write with `wr_en_i` high stores `wr_data_i` into register A when `addr_i` equals 0xD9, and into register B when it equals 0xDA. `rd_data_o` shows the addressed register in the same cycle. Any other address reads 0x00.
- R3: Bit 5 of register A and bit 2 of register B always read 0, and writes to them are dropped.
- R4: While register B bit 0 (the master enable) is 0, no source causes a wake pulse, a release of `stop_n_o` or a counter reload.
- R5: `irq_lines_i[k]` is interrupt line 8+k and is enabled by register A bit k. Index 0 is active-low and the other indices are active-high. Index 5 never wakes. A source whose enable bit is 0 has no effect.
- R6: Register B bits enable the other sources as follows:
  - bit 1: `ring_n_i` (active-low);
  - bit 3: `intr_i`;
  - bit 4: `nmi_i`;
  - bit 5: `smi_i`;
  - bit 6: `ext_smi_i`;
  - bit 7: `susp_btn_i` and `batt_low_i`.
- R7: `ext_smi_i` wakes only while `ext_smi_en_i` is 1. `susp_btn_i` wakes only while `susp_smi_en_i` is 1. `batt_low_i` wakes only while `batt_smi_en_i` is 1.
- R8: Only an inactive-to-active transition of a source wakes the processor, so a held level gives a single pulse and a return to inactive gives none. The wake outputs change SYNC_STAGES+1 clock edges after the input changes.
- R9: A wake sets `brk_pulse_o` for exactly one cycle. In that same cycle `stop_n_o` is 1 and `hold_cnt_o` equals `hold_init_i`.
- R10: `stop_req_i` high drives `stop_n_o` to 0 on the next cycle. If a wake occurs in the same cycle, the wake wins and `stop_n_o` stays 1.
- R11: While `stop_n_o` is 0, `hold_cnt_o` decrements by 1 in every cycle with `tick_i` high and stops at 0. While `stop_n_o` is 1, it changes only on a wake reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Read data of the addressed register |
| irq_lines_i | input | 8 | Interrupt lines 8..15; index 0 is active-low |
| intr_i | input | 1 | Processor interrupt request |
| nmi_i | input | 1 | Non-maskable interrupt |
| smi_i | input | 1 | SMI event |
| ext_smi_i | input | 1 | External SMI event |
| susp_btn_i | input | 1 | Suspend button event |
| batt_low_i | input | 1 | Battery-low event |
| ring_n_i | input | 1 | Serial ring indicate, active-low |
| ext_smi_en_i | input | 1 | SMI enable qualifying external SMI |
| susp_smi_en_i | input | 1 | SMI enable qualifying the suspend button |
| batt_smi_en_i | input | 1 | SMI enable qualifying battery-low |
| stop_req_i | input | 1 | Request to assert the stop output |
| tick_i | input | 1 | Hold counter decrement tick |
| hold_init_i | input | CNT_W | Hold counter reload value |
| stop_n_o | output | 1 | Stop-clock output, active-low |
| hold_cnt_o | output | CNT_W | Hold counter value |
| brk_pulse_o | output | 1 | One-cycle wake pulse |

## Verification
The bench builds the block with CNT_W=4 and SYNC_STAGES=2.

- With a 4-bit counter, a reload value of 3 reaches the zero floor in a few ticks, and the reload check spans almost the whole counter range.
- Two synchronizer stages fix the wake latency at three edges. This lets the bench line up a stop request exactly with a wake to exercise the priority rule.

The vector table walks every source through its enable bit, its polarity and its SMI qualifier.

// File: rtl/clkstop_wake_pkg.sv
package clkstop_wake_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_SRC = 15;

  // physical source positions in the synchronized event vector
  localparam int SRC_RING = 8;
  localparam int SRC_INTR = 9;
  localparam int SRC_NMI  = 10;
  localparam int SRC_SMI  = 11;
  localparam int SRC_XSMI = 12;
  localparam int SRC_SUSP = 13;
  localparam int SRC_BATT = 14;

  // register B field positions
  localparam int B_MASTER = 0;
  localparam int B_RING   = 1;
  localparam int B_INTR   = 3;
  localparam int B_NMI    = 4;
  localparam int B_SMI    = 5;
  localparam int B_XSMI   = 6;
  localparam int B_HWSUS  = 7;

  // writable bits (reserved positions cleared)
  localparam logic [REG_W-1:0] MASK_A = 8'hDF;
  localparam logic [REG_W-1:0] MASK_B = 8'hFB;

  typedef struct packed {
    logic [REG_W-1:0] en_a;
    logic [REG_W-1:0] en_b;
  } wake_cfg_t;
endpackage

// File: rtl/wake_cfg_regs.sv
module wake_cfg_regs
  import clkstop_wake_pkg::*;
#(
  parameter int               ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 8'hD9,
  parameter logic [ADDR_W-1:0] ADDR_B = 8'hDA
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output wake_cfg_t         cfg_o
);
  wake_cfg_t cfg_q, cfg_d;
  logic      sel_a, sel_b;

  always_comb begin
    sel_a = (addr_i == ADDR_A);
    sel_b = (addr_i == ADDR_B);
    cfg_d = cfg_q;
    if (sel_a) cfg_d.en_a = wr_data_i & MASK_A;
    if (sel_b) cfg_d.en_b = wr_data_i & MASK_B;
    if (sel_a)      rd_data_o = cfg_q.en_a;
    else if (sel_b) rd_data_o = cfg_q.en_b;
    else            rd_data_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     cfg_q <= '0;
    else if (wr_en_i) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/wake_sync_edge.sv
module wake_sync_edge #(
  parameter int WIDTH  = 15,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] rise_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] sync_q, sync_d;
    logic              last_q;

    always_comb sync_d = {sync_q[STAGES-2:0], raw_i[g]};

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        sync_q <= '0;
        last_q <= 1'b0;
      end else begin
        sync_q <= sync_d;
        last_q <= sync_q[STAGES-1];
      end
    end

    assign rise_o[g] = sync_q[STAGES-1] & ~last_q;
  end
endmodule

// File: rtl/clkstop_hold_ctr.sv
module clkstop_hold_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             brk_i,
  input  logic             stop_req_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] init_i,
  output logic             stop_n_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             brk_pulse_o
);
  logic             stop_n_q, stop_n_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q;

  always_comb begin
    stop_n_d = stop_n_q;
    cnt_d    = cnt_q;
    if (brk_i) begin
      stop_n_d = 1'b1;
      cnt_d    = init_i;
    end else begin
      if (stop_req_i) stop_n_d = 1'b0;
      if (!stop_n_q && tick_i && (cnt_q != '0)) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stop_n_q <= 1'b1;
      cnt_q    <= '0;
      pulse_q  <= 1'b0;
    end else begin
      stop_n_q <= stop_n_d;
      cnt_q    <= cnt_d;
      pulse_q  <= brk_i;
    end
  end

  assign stop_n_o    = stop_n_q;
  assign cnt_o       = cnt_q;
  assign brk_pulse_o = pulse_q;
endmodule

// File: rtl/clkstop_wake_ctrl.sv
module clkstop_wake_ctrl
  import clkstop_wake_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] ADDR_A      = 8'hD9,
  parameter logic [ADDR_W-1:0] ADDR_B      = 8'hDA,
  parameter int                CNT_W       = 8,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  input  logic [7:0]        irq_lines_i,
  input  logic              intr_i,
  input  logic              nmi_i,
  input  logic              smi_i,
  input  logic              ext_smi_i,
  input  logic              susp_btn_i,
  input  logic              batt_low_i,
  input  logic              ring_n_i,
  input  logic              ext_smi_en_i,
  input  logic              susp_smi_en_i,
  input  logic              batt_smi_en_i,
  input  logic              stop_req_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  hold_init_i,
  output logic              stop_n_o,
  output logic [CNT_W-1:0]  hold_cnt_o,
  output logic              brk_pulse_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe_q <= '0;
    else          rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  wake_cfg_t cfg;
  logic      master_en;

  wake_cfg_regs #(.ADDR_W(ADDR_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)) u_regs (
    .clk_i    (clk_i),
    .rst_n_i  (rst_sync_n),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .cfg_o    (cfg)
  );
  assign master_en = cfg.en_b[B_MASTER];

  // polarity-normalized sources, active-high
  logic [NUM_SRC-1:0] raw_evt, rise;
  assign raw_evt = {batt_low_i, susp_btn_i, ext_smi_i, smi_i, nmi_i, intr_i,
                    ~ring_n_i, irq_lines_i ^ 8'h01};

  wake_sync_edge #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_n_i(rst_sync_n),
    .raw_i  (raw_evt),
    .rise_o (rise)
  );

  logic [REG_W-1:0] hit_a, hit_b;
  logic             brk_hit;

  always_comb begin
    hit_a          = rise[7:0] & cfg.en_a;
    hit_b          = '0;
    hit_b[B_RING]  = rise[SRC_RING] & cfg.en_b[B_RING];
    hit_b[B_INTR]  = rise[SRC_INTR] & cfg.en_b[B_INTR];
    hit_b[B_NMI]   = rise[SRC_NMI]  & cfg.en_b[B_NMI];
    hit_b[B_SMI]   = rise[SRC_SMI]  & cfg.en_b[B_SMI];
    hit_b[B_XSMI]  = rise[SRC_XSMI] & ext_smi_en_i & cfg.en_b[B_XSMI];
    hit_b[B_HWSUS] = ((rise[SRC_SUSP] & susp_smi_en_i) |
                      (rise[SRC_BATT] & batt_smi_en_i)) & cfg.en_b[B_HWSUS];
    brk_hit        = master_en & ((|hit_a) | (|hit_b));
  end

  clkstop_hold_ctr #(.CNT_W(CNT_W)) u_hold (
    .clk_i      (clk_i),
    .rst_n_i    (rst_sync_n),
    .brk_i      (brk_hit),
    .stop_req_i (stop_req_i),
    .tick_i     (tick_i),
    .init_i     (hold_init_i),
    .stop_n_o   (stop_n_o),
    .cnt_o      (hold_cnt_o),
    .brk_pulse_o(brk_pulse_o)
  );
endmodule

// File: rtl/clkstop_wake_chk.sv
module clkstop_wake_chk #(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 8'hD9,
  parameter logic [ADDR_W-1:0] ADDR_B = 8'hDA,
  parameter int                CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              stop_n_o,
  input logic              brk_pulse_o,
  input logic [CNT_W-1:0]  hold_cnt_o,
  input logic [CNT_W-1:0]  hold_init_i,
  input logic              tick_i,
  input logic              stop_req_i,
  input logic              master_en,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rd_data_o
);
  // R9
  release_needs_brk_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(stop_n_o) |-> brk_pulse_o);

  // R9
  brk_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    brk_pulse_o |-> (stop_n_o && (hold_cnt_o == $past(hold_init_i))));

  // R4
  master_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$past(master_en) |-> !brk_pulse_o);

  // R10
  stop_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(stop_req_i) && !brk_pulse_o) |-> !stop_n_o);

  // R11
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!brk_pulse_o && $past(!stop_n_o && tick_i && (hold_cnt_o != '0)))
      |-> (hold_cnt_o == CNT_W'($past(hold_cnt_o) - 1'b1)));

  // R11
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!brk_pulse_o && $past(stop_n_o || !tick_i || (hold_cnt_o == '0)))
      |-> $stable(hold_cnt_o));

  // R3
  rsvd_a_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (addr_i == ADDR_A) |-> !rd_data_o[5]);

  // R3
  rsvd_b_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (addr_i == ADDR_B) |-> !rd_data_o[2]);
endmodule

bind clkstop_wake_ctrl clkstop_wake_chk #(
  .ADDR_W(ADDR_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B), .CNT_W(CNT_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_n      (rst_sync_n),
  .stop_n_o   (stop_n_o),
  .brk_pulse_o(brk_pulse_o),
  .hold_cnt_o (hold_cnt_o),
  .hold_init_i(hold_init_i),
  .tick_i     (tick_i),
  .stop_req_i (stop_req_i),
  .master_en  (master_en),
  .addr_i     (addr_i),
  .rd_data_o  (rd_data_o)
);

// File: tb/clkstop_wake_ctrl_tb_top.sv
module clkstop_wake_ctrl_tb_top;
  localparam int         CNT_W = 4;
  localparam int         SYNC  = 2;
  localparam int         LAT   = SYNC + 1;
  localparam logic [7:0] A_ADR = 8'hD9;
  localparam logic [7:0] B_ADR = 8'hDA;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [7:0]       addr = 8'h00, wdata = 8'h00, rdata;
  logic             wen = 1'b0;
  logic [7:0]       irq = 8'h01;
  logic             intr = 0, nmi = 0, smi = 0, xsmi = 0, susp = 0, batt = 0, ring_n = 1;
  logic             xsmi_en = 0, susp_en = 0, batt_en = 0;
  logic             stop_req = 0, tick = 0;
  logic [CNT_W-1:0] hinit = '0, hcnt;
  logic             stop_n, pulse;

  clkstop_wake_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .addr_i(addr), .wr_en_i(wen), .wr_data_i(wdata),
    .rd_data_o(rdata), .irq_lines_i(irq), .intr_i(intr), .nmi_i(nmi), .smi_i(smi),
    .ext_smi_i(xsmi), .susp_btn_i(susp), .batt_low_i(batt), .ring_n_i(ring_n),
    .ext_smi_en_i(xsmi_en), .susp_smi_en_i(susp_en), .batt_smi_en_i(batt_en),
    .stop_req_i(stop_req), .tick_i(tick), .hold_init_i(hinit),
    .stop_n_o(stop_n), .hold_cnt_o(hcnt), .brk_pulse_o(pulse)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wen = 1'b1;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; #1;
    check(rdata == exp, req, rdata, exp);
  endtask

  // source index: 0..7 irq lines, 8 ring, 9 intr, 10 nmi, 11 smi, 12 ext smi, 13 susp, 14 batt
  task automatic drive_src(input int idx, input logic act);
    if (idx == 0)     irq[0] = ~act;
    else if (idx < 8) irq[idx] = act;
    else case (idx)
      8:  ring_n = ~act;
      9:  intr = act;
      10: nmi = act;
      11: smi = act;
      12: xsmi = act;
      13: susp = act;
      default: batt = act;
    endcase
  endtask

  task automatic stop_pulse();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
  endtask

  // {en_a, en_b, source, {batt_en, susp_en, xsmi_en}, expect wake}
  localparam logic [23:0] VECS [15] = '{
    {8'h01, 8'h01, 4'd0,  3'b000, 1'b1},  // R5 active-low line 8
    {8'h80, 8'h01, 4'd7,  3'b000, 1'b1},  // R5 line 15
    {8'h20, 8'h01, 4'd5,  3'b000, 1'b0},  // R5 index 5 never wakes
    {8'hFF, 8'h00, 4'd1,  3'b000, 1'b0},  // R4 master off
    {8'h00, 8'h03, 4'd8,  3'b000, 1'b1},  // R6 ring, active-low
    {8'h00, 8'h09, 4'd9,  3'b000, 1'b1},  // R6 intr
    {8'h00, 8'h11, 4'd10, 3'b000, 1'b1},  // R6 nmi
    {8'h00, 8'h21, 4'd11, 3'b000, 1'b1},  // R6 smi
    {8'h00, 8'h41, 4'd12, 3'b000, 1'b0},  // R7 ext smi unqualified
    {8'h00, 8'h41, 4'd12, 3'b001, 1'b1},  // R7 ext smi qualified
    {8'h00, 8'h81, 4'd13, 3'b000, 1'b0},  // R7 suspend unqualified
    {8'h00, 8'h81, 4'd13, 3'b010, 1'b1},  // R7 suspend qualified
    {8'h00, 8'h81, 4'd14, 3'b100, 1'b1},  // R7 battery qualified
    {8'h00, 8'h81, 4'd14, 3'b010, 1'b0},  // R7 battery, wrong qualifier
    {8'hFD, 8'h01, 4'd1,  3'b000, 1'b0}   // R5 line disabled
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(stop_n == 1'b1, "R1 stop_n", stop_n, 1);
    check(hcnt == '0, "R1 count", hcnt, 0);
    check(pulse == 1'b0, "R1 pulse", pulse, 0);
    rd_check(A_ADR, 8'h00, "R1 reg A");
    rd_check(B_ADR, 8'h00, "R1 reg B");

    // R2 / R3 register access
    wr(A_ADR, 8'hFF); rd_check(A_ADR, 8'hDF, "R3 reg A reserved");
    wr(B_ADR, 8'hFF); rd_check(B_ADR, 8'hFB, "R3 reg B reserved");
    wr(A_ADR, 8'h5A); rd_check(A_ADR, 8'h5A, "R2 reg A data");
    rd_check(8'hDB, 8'h00, "R2 unmapped address");
    wr(B_ADR, 8'h00);

    // vector walk
    for (int i = 0; i < 15; i++) begin
      logic [23:0] v;
      v = VECS[i];
      wr(A_ADR, v[23:16]);
      wr(B_ADR, v[15:8]);
      {batt_en, susp_en, xsmi_en} = v[3:1];
      hinit = CNT_W'(i + 1);
      stop_pulse();
      @(negedge clk);
      drive_src(int'(v[7:4]), 1'b1);
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      check(pulse == v[0], $sformatf("R9 vec%0d pulse", i), pulse, v[0]);
      check(stop_n == v[0], $sformatf("R9 vec%0d stop_n", i), stop_n, v[0]);
      if (v[0]) check(hcnt == hinit, $sformatf("R9 vec%0d reload", i), hcnt, hinit);
      @(negedge clk);
      check(pulse == 1'b0, $sformatf("R8 vec%0d held level", i), pulse, 0);
      drive_src(int'(v[7:4]), 1'b0);
      repeat (LAT + 1) @(negedge clk);
      check(pulse == 1'b0, $sformatf("R8 vec%0d release edge", i), pulse, 0);
      check(stop_n == v[0], $sformatf("R8 vec%0d stop_n kept", i), stop_n, v[0]);
    end
    {batt_en, susp_en, xsmi_en} = 3'b000;

    // R10: stop request stops the clock, and a wake in the same cycle wins
    wr(A_ADR, 8'h00); wr(B_ADR, 8'h09);
    stop_pulse();
    check(stop_n == 1'b0, "R10 stop request", stop_n, 0);
    hinit = 4'd5;
    @(negedge clk); intr = 1'b1;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    check(stop_n == 1'b1, "R10 wake beats request", stop_n, 1);
    check(pulse == 1'b1, "R10 wake pulse", pulse, 1);
    intr = 1'b0;
    repeat (LAT + 1) @(negedge clk);

    // R11: countdown with floor, frozen while the clock runs
    hinit = 4'd3;
    intr = 1'b1;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    check(hcnt == 4'd3, "R11 reload", hcnt, 3);
    intr = 1'b0;
    tick = 1'b1;
    repeat (3) @(negedge clk);
    check(hcnt == 4'd3, "R11 frozen while running", hcnt, 3);
    tick = 1'b0;
    stop_pulse();
    check(stop_n == 1'b0, "R10 stop asserted", stop_n, 0);
    tick = 1'b1;
    for (int k = 0; k < 4; k++) begin
      int e;
      @(negedge clk);
      e = (2 - k < 0) ? 0 : 2 - k;
      check(hcnt == CNT_W'(e), "R11 countdown", hcnt, e);
    end
    tick = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule